// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block adds or subtracts two 64-bit operands in one of four packings. The operands can be split into eight bytes, four halfwords or two words, or treated as a single 64-bit quantity. Each lane is computed on its own, so no carry or borrow passes from one lane into the next. A per-operation arithmetic mode selects how a lane that overflows is handled. It can wrap around modulo its width, clamp as a signed value, or clamp as an unsigned value.

An operation is started by a one-cycle strobe on `in_valid`, with the operands and the controls presented in the same cycle. On the next clock edge the result is captured into an output register, and `out_valid` is raised for exactly one cycle. The result register keeps its value until the next strobe. Saturation is not defined for the 64-bit packing, so a saturating request at that size returns the wrapped result.

Top module: `simd_addsub`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: With `lane_sel` = 2'b00 (eight 8-bit lanes) and `mode` = 2'b00, each byte of `result` is the low 8 bits of the byte sum of its lane, and no carry passes into the next byte.
- R3: With `lane_sel` = 2'b01 (four 16-bit lanes) or 2'b10 (two 32-bit lanes) and wraparound, each lane holds the low bits of its own sum, and carries cross byte boundaries only inside the lane.
- R4: With `lane_sel` = 2'b11, `result` is the full 64-bit sum or difference of the operands, modulo 2^64.
- R5: When `sub` = 1, each lane computes A minus B. In wraparound mode this is taken modulo 2^w, where w is the lane width.
- R6: With `mode` = 2'b01 (signed saturation), a lane whose signed result exceeds its range becomes the largest positive value, 0 followed by ones. A lane below its range becomes the most negative value, 1 followed by zeros.
- R7: With `mode` = 2'b10 (unsigned saturation), an add that carries out of a lane gives all ones in that lane. A subtract that borrows gives all zeros.
- R8: With `lane_sel` = 2'b11 any `mode` gives the wraparound result. `mode` = 2'b11 gives the wraparound result at every lane size.
- R9: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1. The result of that strobe is on `result` in that same cycle.
- R10: In a cycle without a strobe, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | First operand (minuend when subtracting) |
| op_b | input | 64 | Second operand (subtrahend when subtracting) |
| lane_sel | input | 2 | Lane width: 00 byte, 01 halfword, 10 word, 11 64-bit |
| sub | input | 1 | 0 add, 1 subtract |
| mode | input | 2 | 00 wrap, 01 signed saturate, 10 unsigned saturate, 11 wrap |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 64 | Registered packed result |

## Verification
The model runs the unit on patterns that place carries exactly at lane boundaries. Typical cases are bytes of 0xFF plus 1, and 0x7F/0x80 pairs. With these patterns a carry chain that crosses a lane edge gives a wrong neighbouring lane, which separates it from a correctly segmented one. Signed and unsigned limit values are applied in both add and subtract directions. This catches clamps that take the wrong limit or the wrong sign, and a 64-bit case that saturates when it should wrap. Mixed random operands and idle cycles between strobes then check the timing of the output strobe and that the result holds between strobes.

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        lane_sel,
  input  logic              sub,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;
  localparam int IW = $clog2(NB);

  logic [IW-1:0] lmask;
  logic          sat_s, sat_u;
  logic          cy   [NB+1];
  logic          sovf [NB];
  logic          uovf [NB];
  logic          asgn [NB];
  logic [7:0]    nxt  [NB];
  logic [DATA_W-1:0] nxt_flat;

  assign lmask = IW'((4'd1 << lane_sel) - 4'd1);
  assign sat_s = (mode == 2'b01) && (lane_sel != 2'b11);
  assign sat_u = (mode == 2'b10) && (lane_sel != 2'b11);
  assign cy[0] = sub;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0]    a8, bx, sum8, satv;
    logic          start, top, cin, clamp;
    logic [IW-1:0] tidx;

    assign a8    = op_a[8*i +: 8];
    assign bx    = op_b[8*i +: 8] ^ {8{sub}};
    assign start = ((IW'(i) & lmask) == '0);
    assign top   = ((IW'(i) & lmask) == lmask);
    assign cin   = start ? sub : cy[i];
    assign {cy[i+1], sum8} = {1'b0, a8} + {1'b0, bx} + {8'd0, cin};
    assign asgn[i] = a8[7];
    assign sovf[i] = (a8[7] == bx[7]) && (sum8[7] != a8[7]);
    assign uovf[i] = sub ? ~cy[i+1] : cy[i+1];
    assign tidx  = IW'(i) | lmask;
    assign clamp = (sat_s && sovf[tidx]) || (sat_u && uovf[tidx]);
    assign satv  = sat_s ? (top ? (asgn[tidx] ? 8'h80 : 8'h7F)
                                : (asgn[tidx] ? 8'h00 : 8'hFF))
                         : (sub ? 8'h00 : 8'hFF);
    assign nxt[i] = clamp ? satv : sum8;
    assign nxt_flat[8*i +: 8] = nxt[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt_flat;
    end
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R9
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));  // R10
  AST_QUAD_ADD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b11 && !sub) |=> result == $past(op_a) + $past(op_b));  // R8

  for (genvar k = 0; k < NB; k++) begin : g_chk
    AST_USAT_ADD_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel == 2'b00 && mode == 2'b10 && !sub)
        |=> result[8*k +: 8] >= $past(op_a[8*k +: 8]));  // R7
    AST_USAT_SUB_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel == 2'b00 && mode == 2'b10 && sub)
        |=> result[8*k +: 8] <= $past(op_a[8*k +: 8]));  // R7
    AST_SSAT_POS_STAYS_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_sel == 2'b00 && mode == 2'b01 && !sub
        && !op_a[8*k+7] && !op_b[8*k+7]) |=> !result[8*k+7]);  // R6
  end
endmodule

// File: tb/simd_addsub_tb_top.sv
`timescale 1ns/1ps
module simd_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sel = '0, mode = '0;
  logic        sub = 1'b0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0, errors = 0;
  bit done = 0;
  logic        exp_v = 1'b0;
  logic [63:0] exp_r = '0;
  string       exp_tag = "R1";

  always #2 clk = ~clk;

  simd_addsub dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .op_b(op_b), .lane_sel(lane_sel), .sub(sub), .mode(mode),
    .out_valid(out_valid), .result(result));

  function automatic logic [63:0] ref_op(logic [63:0] a, logic [63:0] b,
                                         logic [1:0] ls, logic s, logic [1:0] m);
    int w = 8 << ls;
    int eff = (w == 64 || m == 2'b11) ? 0 : int'(m);
    logic [63:0] r = '0;
    longint mask, ua, ub, x, hi, lo;
    if (w == 64) return s ? a - b : a + b;
    mask = (64'sd1 <<< w) - 1;
    for (int k = 0; k < 64 / w; k++) begin
      ua = longint'((a >> (k * w)) & 64'(mask));
      ub = longint'((b >> (k * w)) & 64'(mask));
      if (eff == 1) begin
        if (ua >= (64'sd1 <<< (w - 1))) ua -= (64'sd1 <<< w);
        if (ub >= (64'sd1 <<< (w - 1))) ub -= (64'sd1 <<< w);
        hi = (64'sd1 <<< (w - 1)) - 1;
        lo = -(64'sd1 <<< (w - 1));
      end else begin
        hi = mask;
        lo = 0;
      end
      x = s ? ua - ub : ua + ub;
      if (eff != 0) begin
        if (x > hi) x = hi;
        if (x < lo) x = lo;
      end
      r |= (64'(x) & 64'(mask)) << (k * w);
    end
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] ls, logic s, logic [1:0] m);
    if (ls == 2'b11) return (m != 2'b00) ? "R8" : "R4";
    if (m == 2'b11) return "R8";
    if (m == 2'b01) return "R6";
    if (m == 2'b10) return "R7";
    if (s) return "R5";
    return (ls == 2'b00) ? "R2" : "R3";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_r <= '0; exp_tag <= "R1";
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        exp_r   <= ref_op(op_a, op_b, lane_sel, sub, mode);
        exp_tag <= tag_of(lane_sel, sub, mode);
      end else exp_tag <= "R10";
    end
  end

  always @(posedge clk) begin
    #1;
    checks++;
    if (out_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: out_valid=%0b expected %0b", rst_n ? "R9" : "R1", out_valid, exp_v);
    end
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s: result=%h expected %h", exp_tag, result, exp_r);
    end
  end

  task automatic op(logic [63:0] a, logic [63:0] b, logic [1:0] ls, logic s, logic [1:0] m);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; lane_sel = ls; sub = s; mode = m;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
    end
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 5))
      0: return {8{8'hFF}};
      1: return {8{8'h7F}};
      2: return {8{8'h80}};
      3: return {4{16'h7FFF}};
      4: return {$urandom_range(0, 1) ? 8'h01 : 8'h80, 56'h0};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2/R3: carries at lane edges must not leak
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b00, 1'b0, 2'b00);
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b01, 1'b0, 2'b00);
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 1'b0, 2'b00);
    // R4: single 64-bit carry chain
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, 2'b00);
    // R5: borrow stays in lane
    op(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'b00, 1'b1, 2'b00);
    // R6: signed clamps, both directions
    op({8{8'h7F}}, {8{8'h01}}, 2'b00, 1'b0, 2'b01);
    op({8{8'h80}}, {8{8'h01}}, 2'b00, 1'b1, 2'b01);
    op({4{16'h7FFF}}, {4{16'h0001}}, 2'b01, 1'b0, 2'b01);
    op({2{32'h8000_0000}}, {2{32'h0000_0005}}, 2'b10, 1'b1, 2'b01);
    // R7: unsigned clamps
    op({8{8'hF0}}, {8{8'h20}}, 2'b00, 1'b0, 2'b10);
    op({4{16'h0003}}, {4{16'h0009}}, 2'b01, 1'b1, 2'b10);
    // R8: saturating request at 64-bit, and mode 11
    op(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 1'b0, 2'b01);
    op(64'h0, 64'h1, 2'b11, 1'b1, 2'b10);
    op({8{8'h7F}}, {8{8'h01}}, 2'b00, 1'b0, 2'b11);
    // R10: hold while idle
    idle(5);
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else op(pick(), pick(), 2'($urandom), 1'($urandom), 2'($urandom));
    end
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule